// File: doc/BRIEF.md
# Banked Auxiliary Control Register Access Unit

This block serves move-to and move-from coprocessor requests aimed at one 32-bit auxiliary control register. For each request it checks the encoding. It then decides, in the same cycle, whether the access is undefined, trapped to the hypervisor level, or allowed. Allowed accesses read from or write to one of two stored copies of the register: a secure copy and a non-secure copy.

The privilege level of the request and the state of the hypervisor and monitor levels choose the outcome and the copy. Level 0 can never reach the register. At level 1 the hypervisor can claim the access through either of two trap controls. The trap is reported in the form that matches the hypervisor's register width. Levels 1 and 2 use the non-secure copy. Only level 3 uses the non-secure bit, which picks between the two copies. When the monitor level is absent or runs 64-bit, the unbanked register has no separate storage and shares the non-secure slot.

Top module: `auxreg_bank_ctrl`

## Requirements
- R1: The register is selected only when coprocessor=15, opc1=0, CRn=1, CRm=0 and opc2=3. Any other encoding, or a cycle with `req_valid` low, gives all flags 0, `rdata` 0, and does not change storage.
- R2: A selected access at privilege level 0 (`priv_lvl`=2'd0) raises `undef` for reads and writes, and never raises a trap flag.
- R3: At level 1 with `hyp_enabled`=1, if either `hyp_grp_trap` or `hyp_aux_trap` is 1, the access traps. It raises `trap_a64` when `hyp_is32`=0 and `trap_a32` when `hyp_is32`=1. With `hyp_enabled`=0 neither control traps.
- R4: At most one of `undef`, `trap_a64` and `trap_a32` is high. `trap_syndrome` is 6'h03 while a trap flag is high and 0 otherwise.
- R5: The trap controls have no effect at levels 2 and 3.
- R6: Untrapped level-1 accesses and all level-2 accesses use the non-secure copy, whatever the monitor presence or width.
- R7: At level 3, `nonsec`=0 selects the secure copy and `nonsec`=1 selects the non-secure copy.
- R8: All 32 bits of each copy can be written and read back unchanged.
- R9: A synchronous active-low reset clears both copies to zero.
- R10: A write that is undefined or trapped leaves both copies unchanged.
- R11: The outcome flags and read data are valid combinationally in the request cycle. An allowed write takes effect at that cycle's clock edge and is visible to the next request.
- R12: `rdata` is 0 for writes and for undefined or trapped accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| hyp_enabled | input | 1 | Hypervisor level enabled for the current state |
| hyp_is32 | input | 1 | Hypervisor level runs 32-bit |
| hyp_grp_trap | input | 1 | Hypervisor trap for this register group |
| hyp_aux_trap | input | 1 | Hypervisor trap for auxiliary control accesses |
| mon_present | input | 1 | Monitor level implemented |
| mon_is32 | input | 1 | Monitor level runs 32-bit |
| nonsec | input | 1 | Non-secure bit, used at level 3 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| undef | output | 1 | Access is undefined |
| trap_a64 | output | 1 | Trap to a 64-bit hypervisor |
| trap_a32 | output | 1 | Trap to a 32-bit hypervisor |
| trap_syndrome | output | 6 | Trap syndrome code |

## Verification
Some properties are checked by assertions on every cycle. Level 0 always yields undefined, and the outcome flags are mutually exclusive. The syndrome follows the trap flags, and no trap appears at levels 2 and 3. A trap always matches the hypervisor width, and read data stays zero whenever an access is blocked, is a write, or misses the encoding. Blocked writes leave storage stable, a level-3 secure write lands in the secure slot alone, and reset clears both slots. Other behaviour can only be shown by the bench's scenarios, which read the register back through the normal interface. These cover the routing of levels 1 and 2 into the non-secure copy under every monitor setting, the full 32-bit round trip, and the one-cycle visibility of a write.

// File: rtl/auxreg_pkg.sv
package auxreg_pkg;

  localparam int NSLOT = 2;

  typedef enum logic [1:0] {
    LVL_USR = 2'd0,
    LVL_KRN = 2'd1,
    LVL_HYP = 2'd2,
    LVL_MON = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    VERDICT_OK,
    VERDICT_UNDEF,
    VERDICT_TRAP64,
    VERDICT_TRAP32
  } verdict_e;

  typedef enum logic [1:0] {
    COPY_FLAT,
    COPY_NSEC,
    COPY_SEC
  } copy_e;

  // Trap checks in fixed priority: group trap before auxiliary trap,
  // 64-bit flavour before 32-bit flavour within each.
  function automatic verdict_e judge(input priv_e lvl, input logic hyp_en,
                                     input logic hyp_is32, input logic grp_trap,
                                     input logic aux_trap);
    verdict_e v;
    v = VERDICT_OK;
    if (lvl == LVL_USR) begin
      v = VERDICT_UNDEF;
    end else if (lvl == LVL_KRN && hyp_en) begin
      if (grp_trap && !hyp_is32)      v = VERDICT_TRAP64;
      else if (grp_trap && hyp_is32)  v = VERDICT_TRAP32;
      else if (aux_trap && !hyp_is32) v = VERDICT_TRAP64;
      else if (aux_trap && hyp_is32)  v = VERDICT_TRAP32;
    end
    return v;
  endfunction

  function automatic copy_e pick_copy(input priv_e lvl, input logic mon_present,
                                      input logic mon_is32, input logic nonsec);
    if (lvl == LVL_MON) return nonsec ? COPY_NSEC : COPY_SEC;
    return (mon_present && mon_is32) ? COPY_NSEC : COPY_FLAT;
  endfunction

  // The unbanked copy shares the non-secure slot (slot 0); secure is slot 1.
  function automatic logic copy_to_slot(input copy_e c);
    return (c == COPY_SEC);
  endfunction

endpackage

// File: rtl/auxreg_decode.sv
module auxreg_decode #(
  parameter int          CP_W  = 4,
  parameter int          OP1_W = 3,
  parameter int          CR_W  = 4,
  parameter int          OP2_W = 3,
  parameter logic [3:0]  MATCH_CP  = 4'd15,
  parameter logic [2:0]  MATCH_OP1 = 3'd0,
  parameter logic [3:0]  MATCH_CRN = 4'd1,
  parameter logic [3:0]  MATCH_CRM = 4'd0,
  parameter logic [2:0]  MATCH_OP2 = 3'd3
) (
  input  logic [CP_W-1:0]  cp,
  input  logic [OP1_W-1:0] op1,
  input  logic [CR_W-1:0]  crn,
  input  logic [CR_W-1:0]  crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  assign hit = (cp  == CP_W'(MATCH_CP))  &&
               (op1 == OP1_W'(MATCH_OP1)) &&
               (crn == CR_W'(MATCH_CRN))  &&
               (crm == CR_W'(MATCH_CRM))  &&
               (op2 == OP2_W'(MATCH_OP2));
endmodule

// File: rtl/auxreg_judge.sv
module auxreg_judge
  import auxreg_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       hyp_enabled,
  input  logic       hyp_is32,
  input  logic       hyp_grp_trap,
  input  logic       hyp_aux_trap,
  input  logic       mon_present,
  input  logic       mon_is32,
  input  logic       nonsec,
  output verdict_e   verdict,
  output logic       slot_sel
);
  priv_e lvl;
  copy_e copy;

  assign lvl      = priv_e'(priv_lvl);
  assign verdict  = judge(lvl, hyp_enabled, hyp_is32, hyp_grp_trap, hyp_aux_trap);
  assign copy     = pick_copy(lvl, mon_present, mon_is32, nonsec);
  assign slot_sel = copy_to_slot(copy);
endmodule

// File: rtl/auxreg_store.sv
module auxreg_store #(
  parameter int DW    = 32,
  parameter int NSLOT = 2,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_slot,
  input  logic [DW-1:0]            wr_data,
  input  logic [SW-1:0]            rd_slot,
  output logic [DW-1:0]            rd_data,
  output logic [NSLOT-1:0][DW-1:0] slot_q
);
  logic [DW-1:0] mem_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               mem_q[g] <= '0;
      else if (wr_en && wr_slot == SW'(g))      mem_q[g] <= wr_data;
    end
    assign slot_q[g] = mem_q[g];
  end

  assign rd_data = mem_q[rd_slot];
endmodule

// File: rtl/auxreg_bank_ctrl.sv
module auxreg_bank_ctrl
  import auxreg_pkg::*;
#(
  parameter int         DW        = 32,
  parameter int         SYN_W     = 6,
  parameter logic [5:0] TRAP_CODE = 6'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [3:0]       req_cp,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [1:0]       priv_lvl,
  input  logic             hyp_enabled,
  input  logic             hyp_is32,
  input  logic             hyp_grp_trap,
  input  logic             hyp_aux_trap,
  input  logic             mon_present,
  input  logic             mon_is32,
  input  logic             nonsec,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             undef,
  output logic             trap_a64,
  output logic             trap_a32,
  output logic [SYN_W-1:0] trap_syndrome
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic                     req_hit;
  logic                     req_live;
  verdict_e                 verdict;
  logic                     slot_sel;
  logic                     access_ok;
  logic                     wr_fire;
  logic                     rd_fire;
  logic [DW-1:0]            slot_rd;
  logic [NSLOT-1:0][DW-1:0] slot_q;

  auxreg_decode u_decode (
    .cp (req_cp), .op1 (req_op1), .crn (req_crn), .crm (req_crm), .op2 (req_op2),
    .hit (req_hit)
  );

  auxreg_judge u_judge (
    .priv_lvl     (priv_lvl),
    .hyp_enabled  (hyp_enabled),
    .hyp_is32     (hyp_is32),
    .hyp_grp_trap (hyp_grp_trap),
    .hyp_aux_trap (hyp_aux_trap),
    .mon_present  (mon_present),
    .mon_is32     (mon_is32),
    .nonsec       (nonsec),
    .verdict      (verdict),
    .slot_sel     (slot_sel)
  );

  assign req_live  = req_valid && req_hit;
  assign access_ok = req_live && (verdict == VERDICT_OK);
  assign wr_fire   = access_ok && req_write;
  assign rd_fire   = access_ok && !req_write;

  auxreg_store #(.DW(DW), .NSLOT(NSLOT)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_slot (SW'(slot_sel)),
    .wr_data (wdata),
    .rd_slot (SW'(slot_sel)),
    .rd_data (slot_rd),
    .slot_q  (slot_q)
  );

  assign undef         = req_live && (verdict == VERDICT_UNDEF);
  assign trap_a64      = req_live && (verdict == VERDICT_TRAP64);
  assign trap_a32      = req_live && (verdict == VERDICT_TRAP32);
  assign trap_syndrome = (trap_a64 || trap_a32) ? SYN_W'(TRAP_CODE) : '0;
  assign rdata         = rd_fire ? slot_rd : '0;
endmodule

// File: rtl/auxreg_bank_chk.sv
module auxreg_bank_chk #(
  parameter int DW    = 32,
  parameter int SYN_W = 6,
  parameter int NSLOT = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     req_hit,
  input logic [1:0]               priv_lvl,
  input logic                     hyp_enabled,
  input logic                     hyp_is32,
  input logic                     nonsec,
  input logic [DW-1:0]            wdata,
  input logic [DW-1:0]            rdata,
  input logic                     undef,
  input logic                     trap_a64,
  input logic                     trap_a32,
  input logic [SYN_W-1:0]         trap_syndrome,
  input logic [NSLOT-1:0][DW-1:0] slot_q
);
  logic blocked;
  assign blocked = undef || trap_a64 || trap_a32;

  // R2
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit && priv_lvl == 2'd0) |-> (undef && !trap_a64 && !trap_a32));

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef, trap_a64, trap_a32}));

  // R4
  syndrome_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_a64 || trap_a32) |-> (trap_syndrome == SYN_W'(6'h03)));

  // R4
  syndrome_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_a64 || trap_a32) |-> (trap_syndrome == '0));

  // R5
  no_high_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_lvl[1] |-> (!trap_a64 && !trap_a32));

  // R3
  trap64_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_a64 |-> (hyp_enabled && !hyp_is32 && priv_lvl == 2'd1));

  // R3
  trap32_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_a32 |-> (hyp_enabled && hyp_is32 && priv_lvl == 2'd1));

  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_hit) |-> (!blocked && rdata == '0));

  // R12
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked || req_write) |-> (rdata == '0));

  // R10
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && blocked) |=> $stable(slot_q));

  // R7
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit && req_write && priv_lvl == 2'd3 && !nonsec)
      |=> (slot_q[1] == $past(wdata) && $stable(slot_q[0])));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (slot_q == '0));
endmodule

bind auxreg_bank_ctrl auxreg_bank_chk #(.DW(DW), .SYN_W(SYN_W), .NSLOT(auxreg_pkg::NSLOT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_hit       (req_hit),
  .priv_lvl      (priv_lvl),
  .hyp_enabled   (hyp_enabled),
  .hyp_is32      (hyp_is32),
  .nonsec        (nonsec),
  .wdata         (wdata),
  .rdata         (rdata),
  .undef         (undef),
  .trap_a64      (trap_a64),
  .trap_a32      (trap_a32),
  .trap_syndrome (trap_syndrome),
  .slot_q        (slot_q)
);

// File: tb/auxreg_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module auxreg_bank_ctrl_tb_top;

  typedef struct {
    bit        valid, write;
    bit [3:0]  cp;
    bit [2:0]  op1;
    bit [3:0]  crn, crm;
    bit [2:0]  op2;
    bit [1:0]  lvl;
    bit        he, h32, tg, ta, mp, m32, ns;
    bit [31:0] wd;
  } stim_t;

  typedef struct {
    bit [31:0] rd;
    bit        u, t64, t32;
    bit [5:0]  syn;
    string     tag;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_cp = 0, req_crn = 0, req_crm = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0;
  logic [1:0]  priv_lvl = 0;
  logic        hyp_enabled = 0, hyp_is32 = 0, hyp_grp_trap = 0, hyp_aux_trap = 0;
  logic        mon_present = 0, mon_is32 = 0, nonsec = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        undef, trap_a64, trap_a32;
  logic [5:0]  trap_syndrome;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t sb_q[$];
  event drv_ev;
  bit [31:0] m_sec = 0, m_ns = 0;

  always #4 clk = ~clk;

  auxreg_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .priv_lvl(priv_lvl), .hyp_enabled(hyp_enabled),
    .hyp_is32(hyp_is32), .hyp_grp_trap(hyp_grp_trap), .hyp_aux_trap(hyp_aux_trap),
    .mon_present(mon_present), .mon_is32(mon_is32), .nonsec(nonsec),
    .wdata(wdata), .rdata(rdata), .undef(undef), .trap_a64(trap_a64),
    .trap_a32(trap_a32), .trap_syndrome(trap_syndrome)
  );

  function automatic stim_t base(input bit [1:0] lvl, input bit wr, input bit [31:0] wd);
    stim_t s;
    s = '{valid: 1, write: wr, cp: 4'd15, op1: 3'd0, crn: 4'd1, crm: 4'd0, op2: 3'd3,
          lvl: lvl, he: 0, h32: 0, tg: 0, ta: 0, mp: 0, m32: 0, ns: 0, wd: wd};
    return s;
  endfunction

  // Driver: applies one request at the falling edge and records the expectation.
  task automatic xfer(input stim_t s, input string tag);
    exp_t e;
    bit sel, is_sec;
    @(negedge clk);
    req_valid = s.valid; req_write = s.write; req_cp = s.cp; req_op1 = s.op1;
    req_crn = s.crn; req_crm = s.crm; req_op2 = s.op2; priv_lvl = s.lvl;
    hyp_enabled = s.he; hyp_is32 = s.h32; hyp_grp_trap = s.tg; hyp_aux_trap = s.ta;
    mon_present = s.mp; mon_is32 = s.m32; nonsec = s.ns; wdata = s.wd;
    e = '{rd: 0, u: 0, t64: 0, t32: 0, syn: 0, tag: tag};
    sel = s.valid && s.cp == 15 && s.op1 == 0 && s.crn == 1 && s.crm == 0 && s.op2 == 3;
    if (sel) begin
      if (s.lvl == 0) e.u = 1;
      else if (s.lvl == 1 && s.he && (s.tg || s.ta)) begin
        if (s.h32) e.t32 = 1; else e.t64 = 1;
        e.syn = 6'h03;
      end else begin
        is_sec = (s.lvl == 3) && !s.ns;
        if (s.write) begin
          if (is_sec) m_sec = s.wd; else m_ns = s.wd;
        end else begin
          e.rd = is_sec ? m_sec : m_ns;
        end
      end
    end
    sb_q.push_back(e);
    -> drv_ev;
  endtask

  // Monitor: compares outputs one time unit after each request is applied.
  initial begin
    forever begin
      @(drv_ev);
      #1;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (rdata !== e.rd || undef !== e.u || trap_a64 !== e.t64 ||
            trap_a32 !== e.t32 || trap_syndrome !== e.syn) begin
          bad++;
          $display("FAIL %s: got rd=%h u=%b t64=%b t32=%b syn=%h, want rd=%h u=%b t64=%b t32=%b syn=%h",
                   e.tag, rdata, undef, trap_a64, trap_a32, trap_syndrome,
                   e.rd, e.u, e.t64, e.t32, e.syn);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_sec = 0; m_ns = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    do_reset();
    // R9: both copies read zero after reset
    s = base(3, 0, 0); s.ns = 0; xfer(s, "R9 sec reset");
    s = base(3, 0, 0); s.ns = 1; xfer(s, "R9 nsec reset");

    // R7 / R8 / R11: level-3 copy selection and next-cycle visibility
    s = base(3, 1, 32'hA5A5_1234); s.ns = 0; xfer(s, "R7 sec write");
    s = base(3, 0, 0);             s.ns = 0; xfer(s, "R11 sec readback");
    s = base(3, 1, 32'h0F0F_F0F0); s.ns = 1; xfer(s, "R7 nsec write");
    s = base(3, 0, 0);             s.ns = 1; xfer(s, "R7 nsec read");
    s = base(3, 0, 0);             s.ns = 0; xfer(s, "R7 sec unchanged");

    // R6: levels 1 and 2 hit the non-secure copy for every monitor setting
    s = base(2, 0, 0); s.mp = 1; s.m32 = 1; xfer(s, "R6 lvl2 mon32");
    s = base(2, 0, 0); s.mp = 0;            xfer(s, "R6 lvl2 no mon");
    s = base(1, 0, 0); s.mp = 1; s.m32 = 0; s.ns = 0; xfer(s, "R6 lvl1 mon64");
    s = base(1, 1, 32'hFFFF_FFFF); s.mp = 1; s.m32 = 1; xfer(s, "R6 lvl1 write");
    s = base(3, 0, 0); s.ns = 1; xfer(s, "R6 nsec sees lvl1 write");
    s = base(3, 0, 0); s.ns = 0; xfer(s, "R6 sec untouched");

    // R2 / R10: level 0 undefined, write blocked
    s = base(0, 0, 0); xfer(s, "R2 lvl0 read");
    s = base(0, 1, 32'h1111_2222); xfer(s, "R2 lvl0 write");
    s = base(3, 0, 0); s.ns = 1; xfer(s, "R10 after lvl0 write");

    // R3 / R4: trap flavours and priority
    s = base(1, 0, 0); s.he = 1; s.tg = 1; s.h32 = 0; xfer(s, "R3 grp trap 64");
    s = base(1, 0, 0); s.he = 1; s.tg = 1; s.h32 = 1; xfer(s, "R3 grp trap 32");
    s = base(1, 0, 0); s.he = 1; s.ta = 1; s.h32 = 0; xfer(s, "R3 aux trap 64");
    s = base(1, 0, 0); s.he = 1; s.ta = 1; s.h32 = 1; xfer(s, "R4 aux trap 32");
    s = base(1, 1, 32'hDEAD_BEEF); s.he = 1; s.tg = 1; s.ta = 1; xfer(s, "R10 trapped write");
    s = base(3, 0, 0); s.ns = 1; xfer(s, "R10 after trapped write");
    s = base(1, 0, 0); s.he = 0; s.tg = 1; s.ta = 1; xfer(s, "R3 hyp disabled");

    // R5: trap controls ignored at levels 2 and 3
    s = base(2, 0, 0); s.he = 1; s.tg = 1; s.ta = 1; xfer(s, "R5 lvl2 no trap");
    s = base(3, 1, 32'h8000_0001); s.he = 1; s.tg = 1; s.ta = 1; s.ns = 0; xfer(s, "R5 lvl3 write");
    s = base(3, 0, 0); s.ns = 0; xfer(s, "R8 walking ends");

    // R1: each encoding field off by one, write must not land
    s = base(3, 1, 32'h5555_5555); s.ns = 1; s.cp  = 4'd14; xfer(s, "R1 cp miss");
    s = base(3, 1, 32'h5555_5555); s.ns = 1; s.op1 = 3'd1;  xfer(s, "R1 op1 miss");
    s = base(3, 1, 32'h5555_5555); s.ns = 1; s.crn = 4'd0;  xfer(s, "R1 crn miss");
    s = base(3, 1, 32'h5555_5555); s.ns = 1; s.crm = 4'd1;  xfer(s, "R1 crm miss");
    s = base(3, 0, 0);             s.ns = 1; s.op2 = 3'd2;  xfer(s, "R1 op2 miss read");
    s = base(0, 0, 0);                       s.op2 = 3'd1;  xfer(s, "R1 lvl0 miss quiet");
    s = base(3, 1, 32'h7777_7777); s.ns = 1; s.valid = 0;   xfer(s, "R1 invalid write");
    s = base(3, 0, 0); s.ns = 1; xfer(s, "R1 nsec unchanged");

    // R8 / R12: zero pattern round trip, write returns zero data
    s = base(3, 1, 32'h0000_0000); s.ns = 0; xfer(s, "R12 write rdata zero");
    s = base(3, 0, 0); s.ns = 0; xfer(s, "R8 zero readback");

    // R9: reset in mid-run clears both copies
    s = base(3, 1, 32'h1234_5678); s.ns = 0; xfer(s, "R8 pre-reset write");
    do_reset();
    s = base(3, 0, 0); s.ns = 0; xfer(s, "R9 sec cleared");
    s = base(2, 0, 0); xfer(s, "R9 nsec cleared");

    @(negedge clk);
    req_valid = 0;
    repeat (2) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule